// File: doc/BRIEF.md
# Downlink Decode Stage Sequencer

This block is the control state machine of a downlink receiver that must recover a system-information message. It walks the receiver through four channel stages in a fixed order: broadcast-info decode, control-format indexing and decode, control-channel indexing and blind search, and shared-channel indexing and decode. At any moment it enables at most one indexing unit, which is the only requester on the grid read bus, and at most one decoder unit. It watches the done, error, payload and found handshakes of those units.

The synchronizer supplies a subframe strobe with the subframe number. The sequencer keeps a running system frame number (SFN). It loads the SFN from the decoded broadcast value and advances it at every frame rollover. The shared-channel attempt is only allowed to begin at subframe 5 of an even frame. After reset the sequencer clears every decoder's held result for one cycle. It ends in one of three terminal codes and reports its state as a 4-bit code.

Top module: `dl_stage_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state code is 0 (clear), all four bits of `dec_clr` are 1, and no enable is high. On the next cycle the state is 1 (wait for broadcast), `dec_clr` is 0 and the SFN is 0.
- R2: From state 1, the first subframe strobe with subframe number 0 moves the state to 2 (broadcast run). In state 2, bit 0 of `idx_en` and bit 0 of `dec_en` are high.
- R3: In each run state, the indexing enable of that stage drops on the cycle after its `idx_done` bit is seen. The decoder enable of that stage stays high until its `dec_done` bit is seen.
- R4: If `dec_done[0]` arrives with `bc_err` high, or with an all-zero `bc_payload`, the state becomes 8 (broadcast error). The state then stays 8 with all enables low until reset.
- R5: A good broadcast completion loads the SFN from `bc_sfn`. After that, a subframe strobe with number 0 that follows a strobe with number 9 advances the SFN by one modulo 1024. Without a strobe or a load the SFN holds.
- R6: From state 3 (wait for data slot), the state moves to 4 (format run) only on a subframe-5 strobe while the SFN is even (bit 0 = 0). In an odd frame it waits for the next frame.
- R7: The stages run in the order 4 (format, enable bit 1), 5 (search, enable bit 2), 6 (shared, enable bit 3). `dec_done[1]` moves the state from 4 to 5. `dec_done[2]` with `srch_found` high moves it from 5 to 6. With `srch_found` low, the state becomes 9 (search error), which is terminal.
- R8: `dec_done[3]` in state 6 moves the state to 7 (finished), which is terminal with all enables low.
- R9: `idx_en` and `dec_en` each have at most one bit set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sf_strobe | input | 1 | One-cycle pulse at the start of each subframe |
| sf_num | input | 4 | Subframe number 0..9, valid with `sf_strobe` |
| idx_done | input | 4 | Per-stage indexing complete pulse (bit = stage) |
| dec_done | input | 4 | Per-stage decoder complete pulse (bit = stage) |
| bc_err | input | 1 | Broadcast decoder error, valid with `dec_done[0]` |
| bc_payload | input | 24 | Broadcast payload bits, valid with `dec_done[0]` |
| bc_sfn | input | 10 | Decoded frame number, valid with `dec_done[0]` |
| srch_found | input | 1 | Search located the message, valid with `dec_done[2]` |
| idx_en | output | 4 | Indexing unit enables (one-hot or zero) |
| dec_en | output | 4 | Decoder unit enables (one-hot or zero) |
| dec_clr | output | 4 | Decoder output-register clears |
| sfn | output | 10 | Running system frame number |
| state_code | output | 4 | Current state code |

## Verification
Every handshake or strobe is registered on one clock edge. The new state, the enables that decode from it and the SFN are all visible directly after that edge, so every result is due one cycle after its stimulus. The bench drives each pulse for exactly one cycle starting at a falling edge. It then waits for one rising edge and samples at the next falling edge. The expected state and SFN come from a bench model that is advanced in step with each pulse. The clear cycle after reset is checked before the first edge, and the wait state is checked after it.

// File: rtl/dl_seq_pkg.sv
// Package: shared state encoding and stage numbering for the decode sequencer.
// Assumes four stages, numbered in their execution order.
package dl_seq_pkg;

    localparam int NUM_STAGES = 4;
    localparam int STG_BCAST  = 0;
    localparam int STG_FMT    = 1;
    localparam int STG_SRCH   = 2;
    localparam int STG_DATA   = 3;

    typedef enum logic [3:0] {
        ST_CLEAR      = 4'd0,
        ST_BCAST_WAIT = 4'd1,
        ST_BCAST_RUN  = 4'd2,
        ST_SLOT_WAIT  = 4'd3,
        ST_FMT_RUN    = 4'd4,
        ST_SRCH_RUN   = 4'd5,
        ST_DATA_RUN   = 4'd6,
        ST_FINISH     = 4'd7,
        ST_ERR_BCAST  = 4'd8,
        ST_ERR_SRCH   = 4'd9
    } seq_state_e;

endpackage

// File: rtl/dl_sfn_track.sv
// Module: running system frame number.
// Loads on a good broadcast decode. Advances modulo 2**SFN_W when a
// strobe for the first subframe follows a strobe for the last subframe.
// Assumes a strobe carries a valid subframe number. A load wins over a
// simultaneous advance.
module dl_sfn_track #(
    parameter int SFN_W    = 10,
    parameter int SF_W     = 4,
    parameter int FIRST_SF = 0,
    parameter int LAST_SF  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_strobe,
    input  logic [SF_W-1:0]  sf_num,
    input  logic             load,
    input  logic [SFN_W-1:0] load_val,
    output logic [SFN_W-1:0] sfn_o
);

    logic [SFN_W-1:0] sfn_q;
    logic [SF_W-1:0]  last_sf_q;
    logic             rollover;

    // Detect a frame boundary from two consecutive strobes.
    always_comb rollover = sf_strobe && (sf_num == SF_W'(FIRST_SF))
                           && (last_sf_q == SF_W'(LAST_SF));

    // Remember the subframe number of the most recent strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_sf_q <= '0;
        else if (sf_strobe) last_sf_q <= sf_num;
    end

    // Frame counter: load, else advance on rollover.
    always_ff @(posedge clk) begin
        if (!rst_n)        sfn_q <= '0;
        else if (load)     sfn_q <= load_val;
        else if (rollover) sfn_q <= sfn_q + SFN_W'(1);
    end

    assign sfn_o = sfn_q;

    // R5
    sfn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_strobe && !load) |=> $stable(sfn_q));

endmodule

// File: rtl/dl_stage_fsm.sv
// Module: stage state machine of the sequencer.
// Moves through the stages on the decoder done pulses. Gates the broadcast
// stage on the first subframe and the format stage on the data subframe of
// an even frame. Has three terminal states.
// Assumes the status inputs are valid together with the done pulse they
// belong to.
module dl_stage_fsm
    import dl_seq_pkg::*;
#(
    parameter int SF_W     = 4,
    parameter int BCAST_SF = 0,
    parameter int DATA_SF  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sf_strobe,
    input  logic [SF_W-1:0]       sf_num,
    input  logic                  sfn_even,
    input  logic [NUM_STAGES-1:0] dec_done,
    input  logic                  bc_err,
    input  logic                  bc_payload_zero,
    input  logic                  srch_found,
    output seq_state_e            state_o,
    output logic                  load_sfn_o
);

    seq_state_e state_q, state_d;

    // Next-state and frame-load decision.
    always_comb begin
        state_d    = state_q;
        load_sfn_o = 1'b0;
        unique case (state_q)
            ST_CLEAR:      state_d = ST_BCAST_WAIT;
            ST_BCAST_WAIT: if (sf_strobe && sf_num == SF_W'(BCAST_SF))
                               state_d = ST_BCAST_RUN;
            ST_BCAST_RUN:  if (dec_done[STG_BCAST]) begin
                               if (bc_err || bc_payload_zero) begin
                                   state_d = ST_ERR_BCAST;
                               end else begin
                                   state_d    = ST_SLOT_WAIT;
                                   load_sfn_o = 1'b1;
                               end
                           end
            ST_SLOT_WAIT:  if (sf_strobe && sf_num == SF_W'(DATA_SF) && sfn_even)
                               state_d = ST_FMT_RUN;
            ST_FMT_RUN:    if (dec_done[STG_FMT]) state_d = ST_SRCH_RUN;
            ST_SRCH_RUN:   if (dec_done[STG_SRCH])
                               state_d = srch_found ? ST_DATA_RUN : ST_ERR_SRCH;
            ST_DATA_RUN:   if (dec_done[STG_DATA]) state_d = ST_FINISH;
            default:       state_d = state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R4
    bcast_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_BCAST) |=> (state_q == ST_ERR_BCAST));
    // R7
    srch_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_SRCH) |=> (state_q == ST_ERR_SRCH));
    // R8
    finish_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (state_q == ST_FINISH));

endmodule

// File: rtl/dl_unit_gate.sv
// Module: unit enables derived from the stage state.
// Enables one decoder for the active stage. Enables the matching indexing
// unit until that unit reports done. Clears all decoder output registers in
// the clear state.
// Assumes that the state changes only between stages.
module dl_unit_gate
    import dl_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_e            state,
    input  logic [NUM_STAGES-1:0] idx_done,
    output logic [NUM_STAGES-1:0] idx_en,
    output logic [NUM_STAGES-1:0] dec_en,
    output logic [NUM_STAGES-1:0] dec_clr
);

    localparam int STG_W = $clog2(NUM_STAGES);

    seq_state_e       prev_q;
    logic             idx_seen_q;
    logic             active;
    logic             entry;
    logic [STG_W-1:0] stg;

    // Map a run state to its stage number.
    always_comb begin
        active = 1'b1;
        stg    = '0;
        unique case (state)
            ST_BCAST_RUN: stg = STG_W'(STG_BCAST);
            ST_FMT_RUN:   stg = STG_W'(STG_FMT);
            ST_SRCH_RUN:  stg = STG_W'(STG_SRCH);
            ST_DATA_RUN:  stg = STG_W'(STG_DATA);
            default:      active = 1'b0;
        endcase
    end

    // First cycle of a new state.
    always_comb entry = (state != prev_q);

    // Enable decode for the active stage only.
    always_comb begin
        idx_en  = '0;
        dec_en  = '0;
        dec_clr = {NUM_STAGES{state == ST_CLEAR}};
        if (active) begin
            dec_en[stg] = 1'b1;
            idx_en[stg] = !(idx_seen_q && !entry);
        end
    end

    // Track the previous state and whether indexing has finished in this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= ST_CLEAR;
            idx_seen_q <= 1'b0;
        end else begin
            prev_q <= state;
            if (entry) idx_seen_q <= active && idx_done[stg];
            else       idx_seen_q <= idx_seen_q || (active && idx_done[stg]);
        end
    end

    // R3
    idx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(|idx_en) && $stable(state)) |-> $past(|idx_done));

endmodule

// File: rtl/dl_stage_seq.sv
// Module: top of the downlink decode stage sequencer.
// Connects the frame-number tracker, the stage state machine and the
// unit-enable gate. Assumes the decoders and the indexing units obey the
// enables and pulse done for one cycle.
module dl_stage_seq
    import dl_seq_pkg::*;
#(
    parameter int SFN_W    = 10,
    parameter int SF_W     = 4,
    parameter int PAY_W    = 24,
    parameter int BCAST_SF = 0,
    parameter int DATA_SF  = 5,
    parameter int LAST_SF  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sf_strobe,
    input  logic [SF_W-1:0]       sf_num,
    input  logic [NUM_STAGES-1:0] idx_done,
    input  logic [NUM_STAGES-1:0] dec_done,
    input  logic                  bc_err,
    input  logic [PAY_W-1:0]      bc_payload,
    input  logic [SFN_W-1:0]      bc_sfn,
    input  logic                  srch_found,
    output logic [NUM_STAGES-1:0] idx_en,
    output logic [NUM_STAGES-1:0] dec_en,
    output logic [NUM_STAGES-1:0] dec_clr,
    output logic [SFN_W-1:0]      sfn,
    output logic [3:0]            state_code
);

    seq_state_e state;
    logic       load_sfn;
    logic       payload_zero;

    // Flag an empty broadcast payload.
    always_comb payload_zero = (bc_payload == '0);

    dl_sfn_track #(
        .SFN_W(SFN_W), .SF_W(SF_W), .FIRST_SF(0), .LAST_SF(LAST_SF)
    ) sfn_i (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .sf_num(sf_num),
        .load(load_sfn), .load_val(bc_sfn), .sfn_o(sfn)
    );

    dl_stage_fsm #(
        .SF_W(SF_W), .BCAST_SF(BCAST_SF), .DATA_SF(DATA_SF)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .sf_num(sf_num),
        .sfn_even(!sfn[0]), .dec_done(dec_done), .bc_err(bc_err),
        .bc_payload_zero(payload_zero), .srch_found(srch_found),
        .state_o(state), .load_sfn_o(load_sfn)
    );

    dl_unit_gate gate_i (
        .clk(clk), .rst_n(rst_n), .state(state), .idx_done(idx_done),
        .idx_en(idx_en), .dec_en(dec_en), .dec_clr(dec_clr)
    );

    assign state_code = state;

    // R9
    idx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(idx_en));
    // R9
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_en));
    // R2
    bcast_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_en[STG_BCAST]) |-> ($past(sf_strobe) && $past(sf_num) == SF_W'(BCAST_SF)));
    // R6
    fmt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_en[STG_FMT]) |-> ($past(sf_strobe) && $past(sf_num) == SF_W'(DATA_SF)
                                    && !$past(sfn[0])));

endmodule

// File: tb/dl_stage_seq_tb.sv
// Bench: directed and seeded random runs of the whole stage sequence.
module dl_stage_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAY_W      = 24;

    localparam int K_GOOD = 0, K_BCERR = 1, K_ZERO = 2, K_NOFIND = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sf_strobe = 1'b0;
    logic [3:0]       sf_num = '0;
    logic [3:0]       idx_done = '0;
    logic [3:0]       dec_done = '0;
    logic             bc_err = 1'b0;
    logic [PAY_W-1:0] bc_payload = '0;
    logic [9:0]       bc_sfn = '0;
    logic             srch_found = 1'b0;
    logic [3:0]       idx_en, dec_en, dec_clr, state_code;
    logic [9:0]       sfn;

    int n_checks = 0;
    int n_fail   = 0;
    int m_sfn    = 0;
    int m_last   = 0;
    int cur_sf   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dl_stage_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .sf_num(sf_num),
        .idx_done(idx_done), .dec_done(dec_done), .bc_err(bc_err),
        .bc_payload(bc_payload), .bc_sfn(bc_sfn), .srch_found(srch_found),
        .idx_en(idx_en), .dec_en(dec_en), .dec_clr(dec_clr), .sfn(sfn),
        .state_code(state_code)
    );

    function automatic int sfn_step(int cur, int last, int sf);
        if (sf == 0 && last == 9) return (cur + 1) % 1024;
        return cur;
    endfunction

    function automatic int slot_state(int sf, int fr);
        return (sf == 5 && (fr % 2) == 0) ? 4 : 3;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(input int sf);
        sf_num = 4'(sf);
        sf_strobe = 1'b1;
        step();
        sf_strobe = 1'b0;
        m_sfn  = sfn_step(m_sfn, m_last, sf);
        m_last = sf;
    endtask

    task automatic pulse_idx(input int s);
        idx_done[s] = 1'b1;
        step();
        idx_done = '0;
    endtask

    task automatic pulse_dec(input int s);
        dec_done[s] = 1'b1;
        step();
        dec_done = '0;
    endtask

    task automatic run_scn(input int kind, input int bsfn);
        int gap;
        // R1 reset state
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        m_sfn = 0; m_last = 0;
        chk("R1 clear state", int'(state_code), 0);
        chk("R1 clear all", int'(dec_clr), 15);
        chk("R1 no idx_en", int'(idx_en), 0);
        chk("R1 no dec_en", int'(dec_en), 0);
        step();
        chk("R1 wait state", int'(state_code), 1);
        chk("R1 clear off", int'(dec_clr), 0);
        chk("R1 sfn zero", int'(sfn), 0);
        // R2 wait for subframe 0
        cur_sf = $urandom_range(9, 0);
        for (int i = 0; i < 10; i++) begin
            strobe(cur_sf);
            if (cur_sf == 0) break;
            chk("R2 still waiting", int'(state_code), 1);
            cur_sf = (cur_sf + 1) % 10;
        end
        chk("R2 bcast run", int'(state_code), 2);
        chk("R2 idx_en bit0", int'(idx_en), 1);
        chk("R2 dec_en bit0", int'(dec_en), 1);
        gap = $urandom_range(3, 0);
        repeat (gap) step();
        pulse_idx(0);
        chk("R3 idx dropped", int'(idx_en), 0);
        chk("R3 dec held", int'(dec_en), 1);
        // broadcast completion
        bc_err     = (kind == K_BCERR);
        bc_payload = (kind == K_ZERO) ? '0 : (PAY_W'($urandom) | PAY_W'(1));
        bc_sfn     = 10'(bsfn);
        pulse_dec(0);
        bc_err = 1'b0;
        if (kind == K_BCERR || kind == K_ZERO) begin
            chk("R4 bcast error", int'(state_code), 8);
            for (int i = 0; i < 3; i++) begin
                strobe((i + 1) % 10);
                chk("R4 error holds", int'(state_code), 8);
                chk("R4 enables off", int'(dec_en | idx_en), 0);
            end
            return;
        end
        m_sfn = bsfn;
        chk("R5 sfn load", int'(sfn), m_sfn);
        chk("R6 slot wait", int'(state_code), 3);
        // R6 wait for subframe 5 in an even frame
        cur_sf = 1;
        for (int i = 0; i < 25; i++) begin
            int e;
            strobe(cur_sf);
            e = slot_state(cur_sf, m_sfn);
            chk("R6 slot gate", int'(state_code), e);
            chk("R5 sfn track", int'(sfn), m_sfn);
            cur_sf = (cur_sf + 1) % 10;
            if (e == 4) break;
        end
        chk("R7 fmt idx_en", int'(idx_en), 2);
        chk("R7 fmt dec_en", int'(dec_en), 2);
        pulse_idx(1);
        chk("R3 fmt idx dropped", int'(idx_en), 0);
        chk("R3 fmt dec held", int'(dec_en), 2);
        pulse_dec(1);
        chk("R7 search run", int'(state_code), 5);
        chk("R7 search enables", int'({idx_en, dec_en}), 8'h44);
        pulse_idx(2);
        srch_found = (kind != K_NOFIND);
        pulse_dec(2);
        srch_found = 1'b0;
        if (kind == K_NOFIND) begin
            chk("R7 search error", int'(state_code), 9);
            repeat (3) step();
            chk("R7 search error holds", int'(state_code), 9);
            chk("R7 enables off", int'(dec_en | idx_en), 0);
            return;
        end
        chk("R7 data run", int'(state_code), 6);
        chk("R7 data enables", int'({idx_en, dec_en}), 8'h88);
        gap = $urandom_range(12, 0);
        for (int i = 0; i < gap; i++) begin
            strobe(cur_sf);
            cur_sf = (cur_sf + 1) % 10;
            chk("R5 sfn during data", int'(sfn), m_sfn);
            chk("R8 data holds", int'(state_code), 6);
        end
        pulse_dec(3);
        chk("R8 finished", int'(state_code), 7);
        chk("R8 enables off", int'(dec_en | idx_en), 0);
        repeat (2) step();
        chk("R8 finished holds", int'(state_code), 7);
    endtask

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        run_scn(K_GOOD, 10);
        run_scn(K_GOOD, 1023);
        run_scn(K_GOOD, 511);
        run_scn(K_BCERR, 4);
        run_scn(K_ZERO, 6);
        run_scn(K_NOFIND, 7);
        for (int i = 0; i < 40; i++) begin
            int k;
            k = $urandom_range(9, 0);
            run_scn(k < 6 ? K_GOOD : k - 5, $urandom_range(1023, 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule